// File: doc/BRIEF.md
# Debug Control and Status Register File

This block holds the four debug registers of a 32-bit RISC-V style core. They are the debug control/status word, the debug program counter and two scratch words. Two ports load them. The first is a CSR access port: it takes an address, an operation (read, write, set or clear) and write data. It returns the read data in the same cycle and raises an illegal flag. The second is a capture port: when the core halts it loads the halt cause, the privilege level and the address of the next instruction.

Software can reach these registers only while the core is in Debug Mode. Any other attempt is flagged illegal and changes nothing. The control word has:
- a fixed version nibble;
- a read-only cause field;
- two plain read/write bits, for single step and for breakpoint-to-debug in machine mode;
- two legalized fields: the privilege level and breakpoint-to-debug in user mode.

The step, both breakpoint bits, the privilege level and the debug PC are driven out to the core.

Top module: `dbg_csr_file`

## Requirements
- R1: After reset the control word reads 0x4000_0003, and the debug PC and both scratch words read 0. `prv_o` is 3 and `dpc_o` is 0.
- R2: An access with `csr_valid_i` high to any address from 0x7B0 to 0x7B3 while `debug_mode_i` is low raises `csr_illegal_o` in the same cycle, reads 0 and changes no register.
- R3: Bits 31:28 of the control word (address 0x7B0) always read 4 and ignore writes. Bits 27:16, 14:13, 11:9 and 5:3 read as 0.
- R4: Bit 15 (machine-mode breakpoint enters debug) and bit 2 (single step) are plain read/write bits. Their values drive `ebreakm_o` and `step_o` from the cycle after the write.
- R5: Bits 1:0 (privilege) accept only 0 (user) and 3 (machine). This holds for both software writes and captures. Any other value leaves the previous privilege in place.
- R6: Bit 12 (user-mode breakpoint enters debug) keeps the written value when `USER_MODE_EN` is 1, and reads 0 otherwise.
- R7: Bits 8:6 (halt cause) ignore software writes. A capture loads them from `cap_cause_i`, with 1 = breakpoint, 3 = halt request and 4 = single step.
- R8: A capture loads the debug PC (0x7B1) from `cap_pc_i`. Software can still rewrite the debug PC afterwards.
- R9: The operation codes are 0 = read, 1 = write, 2 = set and 3 = clear. Set ORs the write data into the old value, and clear ANDs in its inverse. The result is then legalized like a plain write.
- R10: When a capture and a software write fall in the same cycle, the capture takes effect and the software write is dropped.
- R11: The scratch words at 0x7B2 and 0x7B3 store all 32 bits.
- R12: Read data appears combinationally in the access cycle and shows the value before any write. An address outside 0x7B0 to 0x7B3 reads 0 and is never flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| debug_mode_i | input | 1 | Core is in Debug Mode |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Write data or bit mask |
| csr_rdata_o | output | 32 | Read data (combinational) |
| csr_illegal_o | output | 1 | Access refused outside Debug Mode |
| cap_valid_i | input | 1 | Debug-entry capture strobe |
| cap_cause_i | input | 3 | Halt cause to record |
| cap_prv_i | input | 2 | Privilege at entry |
| cap_pc_i | input | 32 | Next instruction address |
| step_o | output | 1 | Single-step enable |
| ebreakm_o | output | 1 | Machine-mode breakpoint enters debug |
| ebreaku_o | output | 1 | User-mode breakpoint enters debug |
| prv_o | output | 2 | Stored privilege |
| dpc_o | output | 32 | Debug PC |

## Verification
Read data and the illegal flag are combinational. The bench therefore samples them one time unit after it drives an access, before the clock edge that would commit a write. Writes and captures land on the next rising edge. Each update is checked at the following falling edge, either through a fresh read in Debug Mode or on the field outputs, so every result is due exactly one cycle after its stimulus. Accesses refused outside Debug Mode are followed by such a read, which shows that the old value survived.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;

    localparam int unsigned DBG_XLEN        = 32;
    localparam int unsigned DBG_NUM_SCRATCH = 2;
    localparam int unsigned DBG_NUM_REGS    = 2 + DBG_NUM_SCRATCH;
    localparam int unsigned IDX_CTRL        = 0;
    localparam int unsigned IDX_DPC         = 1;
    localparam int unsigned IDX_SCR0        = 2;

    localparam logic [3:0] DBG_VERSION  = 4'd4;
    localparam logic [1:0] PRV_USER     = 2'd0;
    localparam logic [1:0] PRV_MACHINE  = 2'd3;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef struct packed {
        logic                                       ebreakm;
        logic                                       ebreaku;
        logic                                       step;
        logic [1:0]                                 prv;
        logic [2:0]                                 cause;
        logic [DBG_XLEN-1:0]                        dpc;
        logic [DBG_NUM_SCRATCH-1:0][DBG_XLEN-1:0]   scratch;
    } dbg_state_t;

    function automatic logic [1:0] legal_prv(input logic [1:0] req,
                                             input logic [1:0] cur,
                                             input logic       user_en);
        if (req == PRV_MACHINE)               return req;
        if (req == PRV_USER && user_en)       return req;
        return cur;
    endfunction

    function automatic logic [DBG_XLEN-1:0] pack_ctrl(input dbg_state_t s);
        logic [DBG_XLEN-1:0] w;
        w        = '0;
        w[31:28] = DBG_VERSION;
        w[15]    = s.ebreakm;
        w[12]    = s.ebreaku;
        w[8:6]   = s.cause;
        w[2]     = s.step;
        w[1:0]   = s.prv;
        return w;
    endfunction

endpackage

// File: rtl/dbg_csr_decode.sv
module dbg_csr_decode
    import dbg_csr_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h7B0,
    parameter int unsigned     NUM_REGS  = DBG_NUM_REGS
) (
    input  logic                valid_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          op_i,
    input  logic                debug_mode_i,
    output logic [NUM_REGS-1:0] sel_o,
    output logic                wr_en_o,
    output logic                illegal_o
);
    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic              granted;

    assign offset    = addr_i - BASE_ADDR;
    assign hit       = valid_i && (offset < ADDR_W'(NUM_REGS));
    assign granted   = hit && debug_mode_i;
    assign illegal_o = hit && !debug_mode_i;
    assign wr_en_o   = granted && (op_i != OP_READ);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel_o[g] = granted && (offset == ADDR_W'(g));
    end
endmodule

// File: rtl/dbg_csr_rmw.sv
module dbg_csr_rmw
    import dbg_csr_pkg::*;
#(
    parameter int unsigned W = DBG_XLEN
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] new_o
);
    always_comb begin
        unique case (op_i)
            OP_SET:   new_o = old_i | wdata_i;
            OP_CLEAR: new_o = old_i & ~wdata_i;
            OP_WRITE: new_o = wdata_i;
            default:  new_o = old_i;
        endcase
    end
endmodule

// File: rtl/dbg_csr_warl.sv
module dbg_csr_warl
    import dbg_csr_pkg::*;
#(
    parameter bit USER_MODE_EN = 1'b1
) (
    input  logic       ebreakm_req_i,
    input  logic       ebreaku_req_i,
    input  logic       step_req_i,
    input  logic [1:0] prv_req_i,
    input  logic [1:0] prv_cur_i,
    output logic       ebreakm_o,
    output logic       ebreaku_o,
    output logic       step_o,
    output logic [1:0] prv_o
);
    assign ebreakm_o = ebreakm_req_i;
    assign step_o    = step_req_i;
    assign prv_o     = legal_prv(prv_req_i, prv_cur_i, USER_MODE_EN);

    if (USER_MODE_EN) begin : g_user
        assign ebreaku_o = ebreaku_req_i;
    end else begin : g_nouser
        assign ebreaku_o = 1'b0;
    end
endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
    import dbg_csr_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 12'h7B0,
    parameter bit                USER_MODE_EN = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                debug_mode_i,
    input  logic                csr_valid_i,
    input  logic [ADDR_W-1:0]   csr_addr_i,
    input  logic [1:0]          csr_op_i,
    input  logic [DBG_XLEN-1:0] csr_wdata_i,
    output logic [DBG_XLEN-1:0] csr_rdata_o,
    output logic                csr_illegal_o,
    input  logic                cap_valid_i,
    input  logic [2:0]          cap_cause_i,
    input  logic [1:0]          cap_prv_i,
    input  logic [DBG_XLEN-1:0] cap_pc_i,
    output logic                step_o,
    output logic                ebreakm_o,
    output logic                ebreaku_o,
    output logic [1:0]          prv_o,
    output logic [DBG_XLEN-1:0] dpc_o
);
    localparam int unsigned NREG = DBG_NUM_REGS;

    dbg_state_t state_d, state_q;

    logic [NREG-1:0]     sel;
    logic                wr_en;
    logic [DBG_XLEN-1:0] rd_word;
    logic [DBG_XLEN-1:0] new_word;
    logic                w_ebreakm, w_ebreaku, w_step;
    logic [1:0]          w_prv;

    dbg_csr_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .NUM_REGS (NREG)
    ) u_decode (
        .valid_i     (csr_valid_i),
        .addr_i      (csr_addr_i),
        .op_i        (csr_op_i),
        .debug_mode_i(debug_mode_i),
        .sel_o       (sel),
        .wr_en_o     (wr_en),
        .illegal_o   (csr_illegal_o)
    );

    // Read mux: one-hot select, zero when nothing granted.
    always_comb begin
        rd_word = '0;
        if (sel[IDX_CTRL]) rd_word = pack_ctrl(state_q);
        if (sel[IDX_DPC])  rd_word = state_q.dpc;
        for (int i = 0; i < int'(DBG_NUM_SCRATCH); i++) begin
            if (sel[IDX_SCR0 + i]) rd_word = state_q.scratch[i];
        end
    end
    assign csr_rdata_o = rd_word;

    dbg_csr_rmw #(.W(DBG_XLEN)) u_rmw (
        .op_i   (csr_op_i),
        .old_i  (rd_word),
        .wdata_i(csr_wdata_i),
        .new_o  (new_word)
    );

    dbg_csr_warl #(.USER_MODE_EN(USER_MODE_EN)) u_warl (
        .ebreakm_req_i(new_word[15]),
        .ebreaku_req_i(new_word[12]),
        .step_req_i   (new_word[2]),
        .prv_req_i    (new_word[1:0]),
        .prv_cur_i    (state_q.prv),
        .ebreakm_o    (w_ebreakm),
        .ebreaku_o    (w_ebreaku),
        .step_o       (w_step),
        .prv_o        (w_prv)
    );

    // Next-state: capture first, software write otherwise.
    always_comb begin
        state_d = state_q;
        if (cap_valid_i) begin
            state_d.cause = cap_cause_i;
            state_d.prv   = legal_prv(cap_prv_i, state_q.prv, USER_MODE_EN);
            state_d.dpc   = cap_pc_i;
        end else if (wr_en) begin
            if (sel[IDX_CTRL]) begin
                state_d.ebreakm = w_ebreakm;
                state_d.ebreaku = w_ebreaku;
                state_d.step    = w_step;
                state_d.prv     = w_prv;
            end
            if (sel[IDX_DPC]) state_d.dpc = new_word;
            for (int i = 0; i < int'(DBG_NUM_SCRATCH); i++) begin
                if (sel[IDX_SCR0 + i]) state_d.scratch[i] = new_word;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= '0;
            state_q.prv <= PRV_MACHINE;
        end else begin
            state_q <= state_d;
        end
    end

    assign step_o    = state_q.step;
    assign ebreakm_o = state_q.ebreakm;
    assign ebreaku_o = state_q.ebreaku;
    assign prv_o     = state_q.prv;
    assign dpc_o     = state_q.dpc;
endmodule

// File: rtl/dbg_csr_file_chk.sv
module dbg_csr_file_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        debug_mode_i,
    input logic        csr_valid_i,
    input logic [11:0] csr_addr_i,
    input logic [31:0] csr_rdata_o,
    input logic        csr_illegal_o,
    input logic        cap_valid_i,
    input logic [31:0] cap_pc_i,
    input logic        step_o,
    input logic        ebreakm_o,
    input logic        ebreaku_o,
    input logic [1:0]  prv_o,
    input logic [31:0] dpc_o
);
    assert_illegal_nochange_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_illegal_o && !cap_valid_i) |=>
            ($stable(dpc_o) && $stable(prv_o) && $stable(step_o) &&
             $stable(ebreakm_o) && $stable(ebreaku_o)));

    assert_illegal_outside_debug_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> (!debug_mode_i && csr_valid_i && csr_rdata_o == 32'h0));

    assert_version_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_valid_i && debug_mode_i && csr_addr_i == 12'h7B0) |->
            (csr_rdata_o[31:28] == 4'd4));

    assert_prv_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prv_o == 2'd0) || (prv_o == 2'd3));

    assert_capture_dpc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_i |=> (dpc_o == $past(cap_pc_i)));
endmodule

bind dbg_csr_file dbg_csr_file_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .debug_mode_i (debug_mode_i),
    .csr_valid_i  (csr_valid_i),
    .csr_addr_i   (csr_addr_i),
    .csr_rdata_o  (csr_rdata_o),
    .csr_illegal_o(csr_illegal_o),
    .cap_valid_i  (cap_valid_i),
    .cap_pc_i     (cap_pc_i),
    .step_o       (step_o),
    .ebreakm_o    (ebreakm_o),
    .ebreaku_o    (ebreaku_o),
    .prv_o        (prv_o),
    .dpc_o        (dpc_o)
);

// File: tb/tb_dbg_csr_file.sv
module tb_dbg_csr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg = 1'b0;
    logic        valid = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  op = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        illegal;
    logic        cap = 1'b0;
    logic [2:0]  cap_cause = '0;
    logic [1:0]  cap_prv = '0;
    logic [31:0] cap_pc = '0;
    logic        step, ebm, ebu;
    logic [1:0]  prv;
    logic [31:0] dpc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dbg_csr_file dut (
        .clk_i(clk), .rst_ni(rst_n), .debug_mode_i(dbg),
        .csr_valid_i(valid), .csr_addr_i(addr), .csr_op_i(op),
        .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_illegal_o(illegal),
        .cap_valid_i(cap), .cap_cause_i(cap_cause), .cap_prv_i(cap_prv),
        .cap_pc_i(cap_pc), .step_o(step), .ebreakm_o(ebm), .ebreaku_o(ebu),
        .prv_o(prv), .dpc_o(dpc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One access cycle; illegal flag sampled before the committing edge.
    task automatic access(input logic d, input logic [11:0] a, input logic [1:0] o,
                          input logic [31:0] w, output logic ill, output logic [31:0] rd);
        @(negedge clk);
        dbg = d; valid = 1'b1; addr = a; op = o; wdata = w;
        #1;
        ill = illegal; rd = rdata;
        @(posedge clk);
        #1;
        valid = 1'b0; dbg = 1'b1;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] rd);
        logic ill;
        access(1'b1, a, 2'd0, 32'h0, ill, rd);
    endtask

    // {dbg, addr, op, wdata, expected readback, expected illegal}
    localparam int NV = 15;
    localparam logic [79:0] VEC [NV] = '{
        {1'b1, 12'h7B0, 2'd1, 32'hFFFF_FFFF, 32'h4000_9007, 1'b0}, // R3 R4 R6
        {1'b1, 12'h7B0, 2'd1, 32'h0000_0000, 32'h4000_0000, 1'b0}, // R5 prv=0
        {1'b1, 12'h7B0, 2'd1, 32'h0000_0002, 32'h4000_0000, 1'b0}, // R5 prv=2 rejected
        {1'b1, 12'h7B0, 2'd2, 32'h0000_0003, 32'h4000_0003, 1'b0}, // R9 set
        {1'b1, 12'h7B0, 2'd3, 32'h0000_0001, 32'h4000_0003, 1'b0}, // R9 clear -> 2 rejected
        {1'b1, 12'h7B0, 2'd2, 32'h0000_8004, 32'h4000_8007, 1'b0}, // R4
        {1'b1, 12'h7B0, 2'd1, 32'h0000_01C3, 32'h4000_0003, 1'b0}, // R7 cause ignored
        {1'b1, 12'h7B1, 2'd1, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R8
        {1'b1, 12'h7B2, 2'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0}, // R11
        {1'b1, 12'h7B3, 2'd1, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0}, // R11
        {1'b1, 12'h7B3, 2'd3, 32'h0000_F00D, 32'hCAFE_0000, 1'b0}, // R9
        {1'b1, 12'h7B2, 2'd2, 32'h0000_0010, 32'hDEAD_BEFF, 1'b0}, // R9
        {1'b0, 12'h7B1, 2'd1, 32'h0000_0000, 32'h1234_5678, 1'b1}, // R2
        {1'b0, 12'h7B0, 2'd1, 32'h0000_0000, 32'h4000_0003, 1'b1}, // R2
        {1'b1, 12'h7B4, 2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}  // R12
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic        ill;
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dbg   = 1'b1;

        // R1 reset state
        check("R1 prv_o", {30'h0, prv}, 32'd3);
        check("R1 dpc_o", dpc, 32'h0);
        rd_reg(12'h7B0, rd); check("R1 ctrl", rd, 32'h4000_0003);
        rd_reg(12'h7B1, rd); check("R1 dpc", rd, 32'h0);
        rd_reg(12'h7B2, rd); check("R1 scratch0", rd, 32'h0);
        rd_reg(12'h7B3, rd); check("R1 scratch1", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            v = VEC[i];
            access(v[79], v[78:67], v[66:65], v[64:33], ill, rd);
            check($sformatf("R2 vec%0d illegal flag", i), {31'h0, ill}, {31'h0, v[0]});
            if (v[0]) check($sformatf("R2 vec%0d refused read", i), rd, 32'h0);
            rd_reg(v[78:67], rd);
            check($sformatf("vec%0d readback (R3..R12)", i), rd, v[32:1]);
        end

        // R12 read shows pre-write value in the write cycle
        access(1'b1, 12'h7B2, 2'd1, 32'h0000_0001, ill, rd);
        check("R12 pre-write read", rd, 32'hDEAD_BEFF);

        // R4 R6 outputs
        access(1'b1, 12'h7B0, 2'd2, 32'h0000_9004, ill, rd);
        check("R4 step_o", {31'h0, step}, 32'd1);
        check("R4 ebreakm_o", {31'h0, ebm}, 32'd1);
        check("R6 ebreaku_o", {31'h0, ebu}, 32'd1);
        check("R5 prv_o", {30'h0, prv}, 32'd3);

        // R7 R8 capture: cause 4, prv 0, pc 0x100
        @(negedge clk);
        cap = 1'b1; cap_cause = 3'd4; cap_prv = 2'd0; cap_pc = 32'h100;
        @(negedge clk);
        cap = 1'b0;
        check("R8 dpc_o after capture", dpc, 32'h100);
        check("R8 prv_o after capture", {30'h0, prv}, 32'd0);
        rd_reg(12'h7B0, rd); check("R7 ctrl after capture", rd, 32'h4000_9104);

        // R10 capture beats same-cycle write
        @(negedge clk);
        cap = 1'b1; cap_cause = 3'd1; cap_prv = 2'd3; cap_pc = 32'h200;
        dbg = 1'b1; valid = 1'b1; addr = 12'h7B1; op = 2'd1; wdata = 32'hAAAA_AAAA;
        @(negedge clk);
        cap = 1'b0; valid = 1'b0;
        check("R10 dpc_o", dpc, 32'h200);
        rd_reg(12'h7B0, rd); check("R10 ctrl cause", rd, 32'h4000_9047);

        // R5 capture with illegal prv keeps old
        @(negedge clk);
        cap = 1'b1; cap_cause = 3'd3; cap_prv = 2'd2; cap_pc = 32'h300;
        @(negedge clk);
        cap = 1'b0;
        rd_reg(12'h7B0, rd); check("R5 capture prv=2 rejected", rd, 32'h4000_90C7);

        // R8 debug PC writable after capture
        access(1'b1, 12'h7B1, 2'd1, 32'h0000_0444, ill, rd);
        check("R8 dpc rewrite", dpc, 32'h444);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule